// File: doc/BRIEF.md
# Event Counter Bank with Overflow Status

The block counts hardware events on a set of general-purpose counters and a smaller set of fixed-function counters. Each general-purpose counter receives a small per-cycle event count and is governed by its own select register. That register holds a run bit, an interrupt bit and a threshold. Each fixed counter takes a one-bit event strobe and is governed by a 4-bit nibble in a shared control word. That nibble chooses which privilege levels count and whether wrapping raises an interrupt. A global control word adds a second enable bit per counter, so software can start and stop groups of counters with one write.

When any counter wraps past its all-ones value, a sticky bit in a global status word is set. Software clears those bits by writing a mask to a separate clear register. If the wrapping counter has its interrupt enabled, a one-cycle interrupt request pulse is also produced. Software reaches every register through a simple write port and a registered read port. The current privilege level arrives on a single input.

Top module: `perf_counter_bank`

## Requirements
- R1: While reset is high, and after it is released, every counter, select register, control word and status bit reads zero, and pmi_req is low.
- R2: A general-purpose counter advances only when bit 0 of its select register and its global control bit (bit i for counter i) are both 1. With the threshold field zero, it adds its per-cycle event count on each cycle.
- R3: Clearing either the select run bit or the global control bit freezes the counter at its value.
- R4: When the threshold field (select bits 5:2) is non-zero, the counter adds exactly 1 on each cycle whose event count is greater than or equal to the threshold, and adds nothing otherwise.
- R5: Counters are CNT_W bits wide and wrap modulo 2^CNT_W. A counter preset to all ones and given one event reads zero, and its status bit (index i for general-purpose counter i) becomes 1 at the same clock edge.
- R6: A write to a counter takes effect at the clock edge of the write and overrides any increment in that cycle. Counting then continues from the written value.
- R7: pmi_req is a single-cycle pulse, high in the cycle after a wrap, and only if the wrapping counter has its interrupt enabled (select bit 1 for general-purpose counters). A wrap with the interrupt disabled sets status and leaves pmi_req low.
- R8: Writing a mask to the clear register clears exactly those status bits that are 1 in the mask.
- R9: If a clear and a new wrap hit the same status bit in one cycle, the bit stays set.
- R10: Fixed counter j is controlled by control-word bits 4j+3:4j. Bit 0 enables counting while priv_user is 0 (kernel), and bit 1 enables counting while priv_user is 1 (user).
- R11: Fixed counter j uses global control and status index FIX_BASE+j. Nibble bit 3 enables its interrupt on wrap.
- R12: The register map is: 0x00+i general-purpose counter, 0x10+i select, 0x20+j fixed counter, 0x30 fixed control, 0x31 global control, 0x32 status (read-only), 0x33 clear. rd_data shows the register addressed by rd_addr one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | DATA_W | Registered read data |
| gp_evt | input | NUM_GP*EVT_W | Per-cycle event count, one field per general-purpose counter |
| fix_evt | input | NUM_FIX | Per-cycle event strobe for each fixed counter |
| priv_user | input | 1 | 1 in user mode, 0 in kernel mode |
| ovf_status | output | GLB_W | Sticky overflow status word |
| pmi_req | output | 1 | Interrupt request pulse on an enabled wrap |

## Verification
Four rules are checked on every cycle. Status bits never drop without a clear write. A counter stays frozen while either of its enables is off. A counter write lands on the next edge. An interrupt pulse never appears without a set status bit. The arithmetic results can only be shown by the bench's scenarios: threshold counting, wrap values, the choice between kernel and user for fixed counters, the same-cycle race between a clear and a wrap, and the absence of an interrupt when it is disabled.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 4;

  // address regions (upper two address bits)
  localparam logic [1:0] RG_GP_CNT  = 2'd0;
  localparam logic [1:0] RG_GP_SEL  = 2'd1;
  localparam logic [1:0] RG_FIX_CNT = 2'd2;
  localparam logic [1:0] RG_GLOBAL  = 2'd3;

  // registers inside the global region
  localparam logic [IDX_W-1:0] SUB_FIX_CTRL = 4'd0;
  localparam logic [IDX_W-1:0] SUB_GLB_CTRL = 4'd1;
  localparam logic [IDX_W-1:0] SUB_STATUS   = 4'd2;
  localparam logic [IDX_W-1:0] SUB_CLEAR    = 4'd3;

  // select register fields
  localparam int SEL_RUN_BIT = 0;
  localparam int SEL_INT_BIT = 1;
  localparam int SEL_THR_LSB = 2;

  // fixed control nibble fields
  localparam int NIB_KERN_BIT = 0;
  localparam int NIB_USER_BIT = 1;
  localparam int NIB_PMI_BIT  = 3;

  function automatic logic [ADDR_W-1:0] mk_addr(logic [1:0] rg, logic [IDX_W-1:0] idx);
    return {rg, idx};
  endfunction
endpackage

// File: rtl/perf_gp_ctr.sv
module perf_gp_ctr #(
  parameter int CNT_W = 48,
  parameter int EVT_W = 4,
  parameter int THR_W = 4,
  localparam int SEL_W = 2 + THR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr,
  input  logic             sel_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             glb_en,
  input  logic [EVT_W-1:0] evt,
  output logic [CNT_W-1:0] count,
  output logic [SEL_W-1:0] sel,
  output logic             int_en,
  output logic             ovf
);
  import perf_pkg::*;

  localparam int INC_W = CNT_W + 1;
  localparam int CMP_W = (EVT_W > THR_W) ? EVT_W : THR_W;

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [THR_W-1:0] thr;
  logic [INC_W-1:0] inc;
  logic [INC_W-1:0] sum;
  logic             run;

  assign thr = sel_q[SEL_THR_LSB +: THR_W];
  assign run = sel_q[SEL_RUN_BIT] & glb_en;

  always_comb begin
    if (thr == '0)
      inc = INC_W'(evt);
    else if (CMP_W'(evt) >= CMP_W'(thr))
      inc = INC_W'(1);
    else
      inc = '0;
  end

  assign sum = {1'b0, cnt_q} + inc;
  // a software write in the same cycle suppresses the wrap
  assign ovf = run & ~cnt_wr & sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      if (sel_wr) sel_q <= sel_wdata;
      if (cnt_wr)   cnt_q <= cnt_wdata;
      else if (run) cnt_q <= sum[CNT_W-1:0];
    end
  end

  assign count  = cnt_q;
  assign sel    = sel_q;
  assign int_en = sel_q[SEL_INT_BIT];
endmodule

// File: rtl/perf_fix_ctr.sv
module perf_fix_ctr #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             kern_en,
  input  logic             user_en,
  input  logic             priv_user,
  input  logic             glb_en,
  input  logic             evt,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;
  logic             run;

  assign run = (priv_user ? user_en : kern_en) & glb_en & evt;
  assign sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign ovf = run & ~cnt_wr & sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_wr) cnt_q <= cnt_wdata;
    else if (run)    cnt_q <= sum[CNT_W-1:0];
  end

  assign count = cnt_q;
endmodule

// File: rtl/perf_ovf_status.sv
module perf_ovf_status #(
  parameter int GLB_W = 35
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GLB_W-1:0] ovf_vec,
  input  logic [GLB_W-1:0] int_vec,
  input  logic             clr_wr,
  input  logic [GLB_W-1:0] clr_mask,
  output logic [GLB_W-1:0] status,
  output logic             pmi_req
);
  logic [GLB_W-1:0] status_q;
  logic [GLB_W-1:0] kill;
  logic             pmi_q;

  assign kill = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      pmi_q    <= 1'b0;
    end else begin
      // set after clear: a new wrap beats a clear in the same cycle
      status_q <= (status_q & ~kill) | ovf_vec;
      pmi_q    <= |(ovf_vec & int_vec);
    end
  end

  assign status  = status_q;
  assign pmi_req = pmi_q;
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_GP   = 4,
  parameter int NUM_FIX  = 3,
  parameter int CNT_W    = 48,
  parameter int EVT_W    = 4,
  parameter int THR_W    = 4,
  parameter int FIX_BASE = 32,
  localparam int GLB_W   = FIX_BASE + NUM_FIX,
  localparam int DATA_W  = (CNT_W > GLB_W) ? CNT_W : GLB_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [5:0]               wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [5:0]               rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [NUM_GP*EVT_W-1:0]  gp_evt,
  input  logic [NUM_FIX-1:0]       fix_evt,
  input  logic                     priv_user,
  output logic [GLB_W-1:0]         ovf_status,
  output logic                     pmi_req
);
  import perf_pkg::*;

  localparam int SEL_W = 2 + THR_W;
  localparam int FC_W  = 4 * NUM_FIX;

  logic [1:0]       wr_rg, rd_rg;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  assign wr_rg  = wr_addr[ADDR_W-1 -: 2];
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_rg  = rd_addr[ADDR_W-1 -: 2];
  assign rd_idx = rd_addr[IDX_W-1:0];

  logic [FC_W-1:0]  fix_ctrl_q;
  logic [GLB_W-1:0] glb_ctrl_q;
  logic             fc_wr, glb_wr, clr_wr;

  assign fc_wr  = wr_en && wr_rg == RG_GLOBAL && wr_idx == SUB_FIX_CTRL;
  assign glb_wr = wr_en && wr_rg == RG_GLOBAL && wr_idx == SUB_GLB_CTRL;
  assign clr_wr = wr_en && wr_rg == RG_GLOBAL && wr_idx == SUB_CLEAR;

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_ctrl_q <= '0;
      glb_ctrl_q <= '0;
    end else begin
      if (fc_wr)  fix_ctrl_q <= wr_data[FC_W-1:0];
      if (glb_wr) glb_ctrl_q <= wr_data[GLB_W-1:0];
    end
  end

  logic [CNT_W-1:0] gp_cnt  [NUM_GP];
  logic [SEL_W-1:0] gp_sel  [NUM_GP];
  logic [NUM_GP-1:0] gp_ovf, gp_int;
  logic [CNT_W-1:0] fix_cnt [NUM_FIX];
  logic [NUM_FIX-1:0] fix_ovf, fix_int;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic cnt_wr, sel_wr;
    assign cnt_wr = wr_en && wr_rg == RG_GP_CNT && wr_idx == IDX_W'(g);
    assign sel_wr = wr_en && wr_rg == RG_GP_SEL && wr_idx == IDX_W'(g);
    perf_gp_ctr #(.CNT_W(CNT_W), .EVT_W(EVT_W), .THR_W(THR_W)) u_ctr (
      .clk(clk), .rst(rst),
      .cnt_wr(cnt_wr), .sel_wr(sel_wr),
      .cnt_wdata(wr_data[CNT_W-1:0]), .sel_wdata(wr_data[SEL_W-1:0]),
      .glb_en(glb_ctrl_q[g]),
      .evt(gp_evt[g*EVT_W +: EVT_W]),
      .count(gp_cnt[g]), .sel(gp_sel[g]),
      .int_en(gp_int[g]), .ovf(gp_ovf[g])
    );
  end

  for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
    logic cnt_wr;
    logic [3:0] nib;
    assign nib    = fix_ctrl_q[4*f +: 4];
    assign cnt_wr = wr_en && wr_rg == RG_FIX_CNT && wr_idx == IDX_W'(f);
    assign fix_int[f] = nib[NIB_PMI_BIT];
    perf_fix_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst),
      .cnt_wr(cnt_wr), .cnt_wdata(wr_data[CNT_W-1:0]),
      .kern_en(nib[NIB_KERN_BIT]), .user_en(nib[NIB_USER_BIT]),
      .priv_user(priv_user),
      .glb_en(glb_ctrl_q[FIX_BASE + f]),
      .evt(fix_evt[f]),
      .count(fix_cnt[f]), .ovf(fix_ovf[f])
    );
  end

  logic [GLB_W-1:0] ovf_vec, int_vec;
  always_comb begin
    ovf_vec = '0;
    int_vec = '0;
    ovf_vec[NUM_GP-1:0] = gp_ovf;
    int_vec[NUM_GP-1:0] = gp_int;
    ovf_vec[FIX_BASE +: NUM_FIX] = fix_ovf;
    int_vec[FIX_BASE +: NUM_FIX] = fix_int;
  end

  logic [GLB_W-1:0] status;
  perf_ovf_status #(.GLB_W(GLB_W)) u_status (
    .clk(clk), .rst(rst),
    .ovf_vec(ovf_vec), .int_vec(int_vec),
    .clr_wr(clr_wr), .clr_mask(wr_data[GLB_W-1:0]),
    .status(status), .pmi_req(pmi_req)
  );
  assign ovf_status = status;

  logic [DATA_W-1:0] rd_d, rd_q;
  always_comb begin
    rd_d = '0;
    case (rd_rg)
      RG_GP_CNT:
        for (int i = 0; i < NUM_GP; i++)
          if (rd_idx == IDX_W'(i)) rd_d = DATA_W'(gp_cnt[i]);
      RG_GP_SEL:
        for (int i = 0; i < NUM_GP; i++)
          if (rd_idx == IDX_W'(i)) rd_d = DATA_W'(gp_sel[i]);
      RG_FIX_CNT:
        for (int i = 0; i < NUM_FIX; i++)
          if (rd_idx == IDX_W'(i)) rd_d = DATA_W'(fix_cnt[i]);
      default:
        case (rd_idx)
          SUB_FIX_CTRL: rd_d = DATA_W'(fix_ctrl_q);
          SUB_GLB_CTRL: rd_d = DATA_W'(glb_ctrl_q);
          SUB_STATUS:   rd_d = DATA_W'(status);
          default:      rd_d = '0;
        endcase
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end
  assign rd_data = rd_q;
endmodule

// File: rtl/perf_counter_bank_checks.sv
module perf_counter_bank_checks #(
  parameter int CNT_W  = 48,
  parameter int GLB_W  = 35,
  parameter int DATA_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [5:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [GLB_W-1:0]  ovf_status,
  input logic              pmi_req,
  input logic [CNT_W-1:0]  gp0_cnt,
  input logic              gp0_glb,
  input logic              gp0_run
);
  import perf_pkg::*;

  logic clr_hit, gp0_wr;
  assign clr_hit = wr_en && wr_addr == mk_addr(RG_GLOBAL, SUB_CLEAR);
  assign gp0_wr  = wr_en && wr_addr == mk_addr(RG_GP_CNT, 4'd0);

  // R1: outputs are quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pmi_req && ovf_status == '0));

  // R8: status bits only drop on a clear write
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> ((ovf_status & $past(ovf_status)) == $past(ovf_status)));

  // R3: a counter with either enable off holds its value
  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    ((!gp0_glb || !gp0_run) && !gp0_wr) |=> $stable(gp0_cnt));

  // R6: a counter write lands on the next edge
  a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
    gp0_wr |=> gp0_cnt == $past(wr_data[CNT_W-1:0]));

  // R7: an interrupt pulse always comes with a set status bit
  a_r7_pmi_has_status: assert property (@(posedge clk) disable iff (rst)
    pmi_req |-> ovf_status != '0);
endmodule

bind perf_counter_bank perf_counter_bank_checks #(
  .CNT_W(CNT_W), .GLB_W(GLB_W), .DATA_W(DATA_W)
) u_checks (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ovf_status(ovf_status), .pmi_req(pmi_req),
  .gp0_cnt(gp_cnt[0]), .gp0_glb(glb_ctrl_q[0]), .gp0_run(gp_sel[0][0])
);

// File: tb/perf_counter_bank_bench.sv
module perf_counter_bank_bench;
  localparam int CNT_W = 48;
  localparam int GLB_W = 35;
  localparam int DW    = 48;
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [15:0] gp_evt = '0;
  logic [2:0] fix_evt = '0;
  logic priv_user = 1'b0;
  logic [GLB_W-1:0] ovf_status;
  logic pmi_req;

  always #2.5 clk = ~clk;

  perf_counter_bank u_perf_counter_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gp_evt(gp_evt), .fix_evt(fix_evt),
    .priv_user(priv_user), .ovf_status(ovf_status), .pmi_req(pmi_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic rd_req = 1'b0;
  logic rd_seen = 1'b0;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic rd_chk(logic [5:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    rd_addr = a;
    rd_req  = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // monitor side of the scoreboard
  always @(posedge clk) rd_seen <= rd_req;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rd_data, e);
    end
  end

  task automatic wr(logic [5:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_gp(int idx, logic [3:0] v, int n);
    @(negedge clk);
    gp_evt[idx*4 +: 4] = v;
    repeat (n) @(negedge clk);
    gp_evt[idx*4 +: 4] = 4'd0;
  endtask

  task automatic pulse_fix(logic [2:0] m, int n);
    @(negedge clk);
    fix_evt = m;
    repeat (n) @(negedge clk);
    fix_evt = 3'b000;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pmi after reset", DW'(pmi_req), '0);
    check("R1 status after reset", DW'(ovf_status), '0);
    rd_chk(6'h00, '0, "R1 counter0 reset");
    rd_chk(6'h31, '0, "R1 global control reset");

    // R2 both enables needed
    wr(6'h10, 48'h1);
    pulse_gp(0, 4'd3, 5);
    rd_chk(6'h00, 48'd0, "R2 no count without global bit");
    wr(6'h31, 48'h1);
    pulse_gp(0, 4'd3, 5);
    rd_chk(6'h00, 48'd15, "R2 counts event sum");
    rd_chk(6'h10, 48'h1, "R12 select readback");
    // R3 freeze by either enable
    wr(6'h10, 48'h0);
    pulse_gp(0, 4'd3, 5);
    rd_chk(6'h00, 48'd15, "R3 frozen by select");
    wr(6'h10, 48'h1);
    wr(6'h31, 48'h0);
    pulse_gp(0, 4'd3, 5);
    rd_chk(6'h00, 48'd15, "R3 frozen by global");

    // R4 threshold 4
    wr(6'h10, 48'h11);
    wr(6'h31, 48'h1);
    wr(6'h00, 48'h0);
    pulse_gp(0, 4'd5, 3);
    pulse_gp(0, 4'd3, 2);
    pulse_gp(0, 4'd4, 1);
    rd_chk(6'h00, 48'd4, "R4 threshold counting");

    // R6 write while running
    wr(6'h10, 48'h1);
    @(negedge clk);
    gp_evt[3:0] = 4'd1;
    wr(6'h00, 48'd100);
    repeat (3) @(negedge clk);
    gp_evt[3:0] = 4'd0;
    rd_chk(6'h00, 48'd103, "R6 continues from written value");
    wr(6'h10, 48'h0);

    // R5 / R7 preset all ones with interrupt
    wr(6'h31, 48'h3);
    wr(6'h11, 48'h3);
    wr(6'h01, ONES);
    pulse_gp(1, 4'd1, 1);
    check("R7 pmi pulse on enabled wrap", DW'(pmi_req), 48'd1);
    check("R5 status bit 1 set", DW'(ovf_status), 48'h2);
    @(negedge clk);
    check("R7 pmi lasts one cycle", DW'(pmi_req), 48'd0);
    rd_chk(6'h01, 48'd0, "R5 wrap to zero");

    // R7 wrap without interrupt
    wr(6'h31, 48'h7);
    wr(6'h12, 48'h1);
    wr(6'h02, ONES - 48'd1);
    pulse_gp(2, 4'd3, 1);
    check("R7 no pmi when disabled", DW'(pmi_req), 48'd0);
    check("R5 status bit 2 set", DW'(ovf_status), 48'h6);
    rd_chk(6'h02, 48'd1, "R5 modulo wrap value");

    // R8 clear by mask
    wr(6'h33, 48'h2);
    check("R8 clear bit 1 only", DW'(ovf_status), 48'h4);
    rd_chk(6'h32, 48'h4, "R12 status readback");

    // R9 clear racing a new wrap
    wr(6'h02, ONES);
    @(negedge clk);
    gp_evt[11:8] = 4'd1;
    wr_en = 1'b1; wr_addr = 6'h33; wr_data = 48'h4;
    @(negedge clk);
    gp_evt[11:8] = 4'd0;
    wr_en = 1'b0;
    check("R9 wrap beats clear", DW'(ovf_status), 48'h4);

    // R10 fixed counters by privilege
    wr(6'h30, 48'h021);
    wr(6'h31, 48'h7_0000_0007);
    priv_user = 1'b0;
    pulse_fix(3'b011, 4);
    priv_user = 1'b1;
    pulse_fix(3'b011, 3);
    rd_chk(6'h20, 48'd4, "R10 kernel-only fixed counter");
    rd_chk(6'h21, 48'd3, "R10 user-only fixed counter");

    // R11 fixed wrap index and interrupt nibble bit
    priv_user = 1'b0;
    wr(6'h30, 48'h921);
    wr(6'h22, ONES);
    pulse_fix(3'b100, 1);
    check("R11 fixed pmi pulse", DW'(pmi_req), 48'd1);
    check("R11 fixed status index", DW'(ovf_status), 48'h4_0000_0004);
    wr(6'h20, ONES);
    pulse_fix(3'b001, 1);
    check("R11 fixed no pmi without nibble bit", DW'(pmi_req), 48'd0);
    check("R11 fixed status index 32", DW'(ovf_status), 48'h5_0000_0004);

    repeat (4) @(negedge clk);
    check("R12 scoreboard drained", DW'(exp_q.size()), '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule